// File: doc/BRIEF.md
# Card Reset and Power-Good Sequencer

This block sits beside the power switches of a hot-pluggable card slot and turns three per-rail "within tolerance" flags into the two control signals the card depends on: a shared clock-enable line that doubles as a power-good indication, and an active-low card reset. The clock-enable line is wired-AND. The block only ever pulls it low, a pull-up raises it, and any other agent on the board may also hold it low to postpone the card coming out of reset.

While any rail is out of tolerance the block pulls the clock-enable line low and holds card reset asserted. When every rail is good it lets the line go. The reset-release timer then runs from the moment the line is actually seen high, so an outside hold-low lengthens the total delay. A host warm-reset input forces card reset without touching the clock-enable line. A minimum-width counter makes sure that every card reset pulse, whatever caused it, lasts long enough. The host reset and the sensed line level are asynchronous and each passes through its own synchronizer. The rail flags are already synchronous to the block clock.

With the default parameters at a 125 MHz clock the release delay is 2 ms and the minimum reset width is 100 us. Elaboration checks keep those values inside the 1 ms to 20 ms window and at or above 100 us unless the timing check is turned off for short test configurations.

Top module: `card_rst_seq`

## Requirements
- R1: During reset and until all rails are good, `clken_pull_low` is 1 and `card_rst_n` is 0.
- R2: If any bit of `rails_ok` is 0 before clock edge k, `clken_pull_low` is 1 after edge k.
- R3: If all bits of `rails_ok` are 1 before clock edge k, `clken_pull_low` is 0 after edge k.
- R4: While `clken_sense` is held low, `card_rst_n` stays 0. If `clken_sense` goes high before edge a and stays high, with the rails good, no warm reset and the minimum width already met, then `card_rst_n` becomes 1 at edge a+RELEASE_CYCLES+2.
- R5: If `clken_sense` is seen low again before the delay completes, the delay count restarts from zero at the next high level.
- R6: On a rail loss, `clken_pull_low` rises one edge before `card_rst_n` falls, and `card_rst_n` is 0 after every edge that follows a cycle with `clken_pull_low` at 1.
- R7: If `host_rst_n` is 0 before edge a, `card_rst_n` is 0 after edge a+2, which is 24 ns at 125 MHz and well inside 500 ns. Warm reset never changes `clken_pull_low`.
- R8: Once `card_rst_n` falls it stays 0 for at least MIN_LOW_CYCLES clock cycles. A warm-reset pulse one cycle long gives a reset exactly MIN_LOW_CYCLES cycles long.
- R9: If warm reset is released before edge b with the rails good and the delay already completed once, `card_rst_n` returns to 1 at edge b+2 if the minimum width is met by then, and otherwise as soon as it is met. The release delay is not run again.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low block reset |
| rails_ok | input | NUM_RAILS | Per-rail within-tolerance flags, synchronous, 1 = good |
| host_rst_n | input | 1 | Host warm reset, active low, asynchronous |
| clken_sense | input | 1 | Sensed level of the wired-AND clock-enable line |
| clken_pull_low | output | 1 | 1 = pull the clock-enable line low (open-drain control) |
| card_rst_n | output | 1 | Card reset, active low |

## Verification
A stale timer state would show up at `card_rst_n` as a release that comes early, comes late, or never comes, measured in edges from the first high sample of the line, so a one-cycle error is caught on the release edge itself. A minimum-width counter that is not cleared would show up as a short pulse after a one-cycle warm reset, within MIN_LOW_CYCLES cycles of the pulse. Wrong ordering on power loss shows up within two edges: `card_rst_n` falls in the same cycle as `clken_pull_low` rises, or falls without it. A behavioural model compares both outputs on every cycle through long random stretches of rail drops, hold-lows and warm resets, so divergent state appears at the first cycle it reaches a port.

// File: rtl/card_rst_seq_pkg.sv
package card_rst_seq_pkg;

   // Width of a counter that holds the values 0 .. n-1 (never below 1 bit)
   function automatic int unsigned span_width(input int unsigned n);
      return (n < 2) ? 1 : $clog2(n);
   endfunction

   // Release-timer phases
   typedef enum logic [1:0] {
      TMR_IDLE = 2'd0,   // waiting for the line to be seen high
      TMR_RUN  = 2'd1,   // counting the release delay
      TMR_DONE = 2'd2    // delay completed since the last rail loss
   } tmr_state_e;

endpackage

// File: rtl/crs_sync.sv
module crs_sync #(
   parameter int unsigned STAGES  = 2,
   parameter logic        RST_VAL = 1'b0
) (
   input  logic clk,
   input  logic rst_n,
   input  logic d,
   output logic q
);
   logic [STAGES-1:0] chain;

   for (genvar g = 0; g < STAGES; g++) begin : g_stage
      if (g == 0) begin : g_first
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[0] <= RST_VAL;
            else        chain[0] <= d;
         end
      end else begin : g_next
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) chain[g] <= RST_VAL;
            else        chain[g] <= chain[g-1];
         end
      end
   end

   assign q = chain[STAGES-1];
endmodule

// File: rtl/crs_release_timer.sv
module crs_release_timer
   import card_rst_seq_pkg::*;
#(
   parameter int unsigned DELAY_CYCLES = 250000
) (
   input  logic clk,
   input  logic rst_n,
   input  logic rails_bad,
   input  logic line_high,
   output logic ready
);
   localparam int unsigned      CW   = span_width(DELAY_CYCLES);
   localparam logic [CW-1:0]    LAST = CW'(DELAY_CYCLES - 1);
   localparam logic [CW-1:0]    ONE  = CW'(1);

   tmr_state_e    state;
   logic [CW-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state <= TMR_IDLE;
         cnt   <= '0;
      end else if (rails_bad) begin
         state <= TMR_IDLE;
         cnt   <= '0;
      end else begin
         unique case (state)
            TMR_IDLE: begin
               if (line_high) begin
                  if (LAST == '0) state <= TMR_DONE;
                  else begin
                     state <= TMR_RUN;
                     cnt   <= ONE;
                  end
               end
            end
            TMR_RUN: begin
               if (!line_high) begin
                  state <= TMR_IDLE;
                  cnt   <= '0;
               end else if (cnt == LAST) begin
                  state <= TMR_DONE;
               end else begin
                  cnt <= cnt + ONE;
               end
            end
            TMR_DONE: state <= TMR_DONE;
            default: begin
               state <= TMR_IDLE;
               cnt   <= '0;
            end
         endcase
      end
   end

   assign ready = (state == TMR_DONE);
endmodule

// File: rtl/crs_min_width.sv
module crs_min_width
   import card_rst_seq_pkg::*;
#(
   parameter int unsigned MIN_CYCLES = 12500
) (
   input  logic clk,
   input  logic rst_n,
   input  logic held_low,
   output logic met
);
   localparam int unsigned   CW   = span_width(MIN_CYCLES);
   localparam logic [CW-1:0] LAST = CW'(MIN_CYCLES - 1);

   logic [CW-1:0] run;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            run <= '0;
      else if (!held_low)    run <= '0;
      else if (run != LAST)  run <= run + CW'(1);
   end

   assign met = (run == LAST);
endmodule

// File: rtl/card_rst_seq.sv
module card_rst_seq #(
   parameter int unsigned NUM_RAILS      = 3,
   parameter int unsigned SYNC_STAGES    = 2,
   parameter int unsigned CLK_KHZ        = 125000,
   parameter int unsigned RELEASE_CYCLES = 250000,
   parameter int unsigned MIN_LOW_CYCLES = 12500,
   parameter bit          ENFORCE_TIMING = 1'b1
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [NUM_RAILS-1:0] rails_ok,
   input  logic                 host_rst_n,
   input  logic                 clken_sense,
   output logic                 clken_pull_low,
   output logic                 card_rst_n
);
   localparam int unsigned KHZ_1MS   = CLK_KHZ;
   localparam int unsigned KHZ_20MS  = 20 * CLK_KHZ;
   localparam int unsigned KHZ_100US = CLK_KHZ / 10;
   localparam int unsigned WORST_REL = RELEASE_CYCLES + SYNC_STAGES + 2;

   if (NUM_RAILS < 1)      $error("NUM_RAILS must be at least 1");
   if (SYNC_STAGES < 2)    $error("SYNC_STAGES must be at least 2");
   if (RELEASE_CYCLES < 1) $error("RELEASE_CYCLES must be at least 1");
   if (MIN_LOW_CYCLES < 1) $error("MIN_LOW_CYCLES must be at least 1");
   if (ENFORCE_TIMING) begin : g_timing
      if (RELEASE_CYCLES < KHZ_1MS)  $error("release delay below 1 ms");
      if (WORST_REL > KHZ_20MS)      $error("release delay above 20 ms");
      if (MIN_LOW_CYCLES < KHZ_100US) $error("reset width below 100 us");
   end

   logic rails_bad;
   logic warm_req;
   logic line_high;
   logic pwr_ready;
   logic min_met;
   logic held_low;
   logic card_rst_n_d;

   assign rails_bad = ~(&rails_ok);

   // Open-drain pull control, registered so that it leads the reset by an edge
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) clken_pull_low <= 1'b1;
      else        clken_pull_low <= rails_bad;
   end

   crs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_warm_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (~host_rst_n),
      .q     (warm_req)
   );

   crs_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_line_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (clken_sense),
      .q     (line_high)
   );

   crs_release_timer #(.DELAY_CYCLES(RELEASE_CYCLES)) u_timer (
      .clk       (clk),
      .rst_n     (rst_n),
      .rails_bad (clken_pull_low),
      .line_high (line_high),
      .ready     (pwr_ready)
   );

   assign held_low = ~card_rst_n;

   crs_min_width #(.MIN_CYCLES(MIN_LOW_CYCLES)) u_minw (
      .clk      (clk),
      .rst_n    (rst_n),
      .held_low (held_low),
      .met      (min_met)
   );

   assign card_rst_n_d = ~(clken_pull_low | warm_req | ~pwr_ready |
                           (held_low & ~min_met));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) card_rst_n <= 1'b0;
      else        card_rst_n <= card_rst_n_d;
   end
endmodule

// File: rtl/card_rst_seq_chk.sv
module card_rst_seq_chk #(
   parameter int unsigned NUM_RAILS      = 3,
   parameter int unsigned MIN_LOW_CYCLES = 12500
) (
   input logic                 clk,
   input logic                 rst_n,
   input logic [NUM_RAILS-1:0] rails_ok,
   input logic                 clken_pull_low,
   input logic                 card_rst_n,
   input logic                 warm_req
);
   int unsigned low_len;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                       low_len <= 0;
      else if (card_rst_n)              low_len <= 0;
      else if (low_len < MIN_LOW_CYCLES) low_len <= low_len + 1;
   end

   // R2
   rail_bad_pull_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !(&rails_ok) |=> clken_pull_low);

   // R3
   rail_good_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (&rails_ok) |=> !clken_pull_low);

   // R6
   pull_forces_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clken_pull_low |=> !card_rst_n);

   // R6
   pull_before_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($rose(clken_pull_low) && $past(card_rst_n) && !$past(warm_req)) |-> card_rst_n);

   // R7
   warm_forces_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
      warm_req |=> !card_rst_n);

   // R8
   min_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(card_rst_n) |-> (low_len >= MIN_LOW_CYCLES));
endmodule

bind card_rst_seq card_rst_seq_chk #(
   .NUM_RAILS      (NUM_RAILS),
   .MIN_LOW_CYCLES (MIN_LOW_CYCLES)
) u_chk (
   .clk            (clk),
   .rst_n          (rst_n),
   .rails_ok       (rails_ok),
   .clken_pull_low (clken_pull_low),
   .card_rst_n     (card_rst_n),
   .warm_req       (warm_req)
);

// File: tb/card_rst_seq_test.sv
module card_rst_seq_test;
   localparam int REL  = 40;
   localparam int MINW = 30;
   localparam int SYNC = 2;
   localparam int NR   = 3;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [NR-1:0] rails = '0;
   logic          host_rst_n = 1'b1;
   logic          ext_hold = 1'b0;
   logic          clken_pull_low;
   logic          card_rst_n;
   wire           clken_sense = ~clken_pull_low & ~ext_hold;

   always #4 clk = ~clk;   // 125 MHz

   card_rst_seq #(
      .NUM_RAILS(NR), .SYNC_STAGES(SYNC), .CLK_KHZ(125000),
      .RELEASE_CYCLES(REL), .MIN_LOW_CYCLES(MINW), .ENFORCE_TIMING(1'b0)
   ) uut (
      .clk(clk), .rst_n(rst_n), .rails_ok(rails), .host_rst_n(host_rst_n),
      .clken_sense(clken_sense), .clken_pull_low(clken_pull_low),
      .card_rst_n(card_rst_n)
   );

   int    vectors = 0;
   int    misses = 0;
   int    cycles = 0;
   bit    done = 0;
   string tag = "R1";

   // Behavioural reference: queues model the synchronizer latency
   bit m_pull = 1;
   bit m_card = 0;
   bit m_ready = 0;
   int m_cnt = 0;
   int m_low = 0;
   bit warm_q[$];
   bit line_q[$];

   initial begin
      for (int i = 0; i < SYNC; i++) begin
         warm_q.push_back(1'b0);
         line_q.push_back(1'b0);
      end
   end

   always @(posedge clk) begin
      bit warm_now, line_now, n_pull, n_card, n_ready, line_in;
      int n_cnt, n_low;
      if (!rst_n) begin
         m_pull = 1; m_card = 0; m_ready = 0; m_cnt = 0; m_low = 0;
         for (int i = 0; i < SYNC; i++) begin
            warm_q[i] = 1'b0;
            line_q[i] = 1'b0;
         end
      end else begin
         warm_now = warm_q[SYNC-1];
         line_now = line_q[SYNC-1];
         line_in  = !m_pull && !ext_hold;
         n_pull   = !(&rails);
         n_card   = !(m_pull || warm_now || !m_ready || (!m_card && m_low < MINW-1));
         n_ready  = m_ready;
         n_cnt    = m_cnt;
         if (m_pull) begin
            n_ready = 0; n_cnt = 0;
         end else if (!line_now) begin
            n_cnt = 0;
         end else if (!m_ready) begin
            if (m_cnt == REL-1) n_ready = 1;
            else                n_cnt = m_cnt + 1;
         end
         n_low = m_card ? 0 : ((m_low < MINW-1) ? m_low + 1 : m_low);
         void'(warm_q.pop_back());
         warm_q.push_front(!host_rst_n);
         void'(line_q.pop_back());
         line_q.push_front(line_in);
         m_pull = n_pull; m_card = n_card; m_ready = n_ready;
         m_cnt = n_cnt; m_low = n_low;
      end
   end

   task automatic check(input string req, input string what, input logic act, input logic exp);
      vectors++;
      if (act !== exp) begin
         misses++;
         $display("FAIL %s %s actual %b expected %b at cycle %0d", req, what, act, exp, cycles);
      end
   endtask

   task automatic check_int(input string req, input string what, input int act, input int exp);
      vectors++;
      if (act != exp) begin
         misses++;
         $display("FAIL %s %s actual %0d expected %0d", req, what, act, exp);
      end
   endtask

   // Every-cycle comparison against the model
   always @(negedge clk) begin
      if (rst_n && !done) begin
         check(tag, "model clken_pull_low", clken_pull_low, m_pull);
         check(tag, "model card_rst_n", card_rst_n, m_card);
      end
   end

   always @(posedge clk) begin
      cycles++;
      if (cycles > 60000 && !done) begin
         done = 1;
         misses++;
         $display("FAIL watchdog expired actual %0d expected below 60000", cycles);
         $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   task automatic step(input int n);
      for (int i = 0; i < n; i++) @(negedge clk);
   endtask

   // Edges from the current negedge until card_rst_n shows val
   task automatic edges_until(input logic val, input int limit, output int lat);
      lat = 0;
      while (lat < limit) begin
         @(posedge clk);
         lat++;
         @(negedge clk);
         if (card_rst_n === val) break;
      end
   endtask

   initial begin
      int lat;
      int lowc;
      @(negedge clk);
      step(4);
      check("R1", "reset card_rst_n", card_rst_n, 1'b0);
      check("R1", "reset clken_pull_low", clken_pull_low, 1'b1);
      rst_n = 1'b1;
      step(5);
      check("R1", "rails bad card_rst_n", card_rst_n, 1'b0);
      check("R1", "rails bad clken_pull_low", clken_pull_low, 1'b1);

      // R3 / R4: rails good, line held low outside
      tag = "R4";
      ext_hold = 1'b1;
      rails = '1;
      step(1);
      check("R3", "pull released after good rails", clken_pull_low, 1'b0);
      step(100);
      check("R4", "reset held while line low", card_rst_n, 1'b0);
      ext_hold = 1'b0;
      edges_until(1'b1, 500, lat);
      check_int("R4", "release latency edges", lat, REL + 3);

      // R2 / R6: rail loss ordering
      tag = "R6";
      rails = 3'b101;
      ext_hold = 1'b1;
      step(1);
      check("R2", "pull after rail loss", clken_pull_low, 1'b1);
      check("R6", "reset not yet asserted", card_rst_n, 1'b1);
      step(1);
      check("R6", "reset asserted after pull", card_rst_n, 1'b0);

      // R5: aborted count restarts
      tag = "R5";
      rails = '1;
      step(10);
      ext_hold = 1'b0;
      step(10);
      ext_hold = 1'b1;
      step(10);
      check("R5", "no release after short high", card_rst_n, 1'b0);
      ext_hold = 1'b0;
      edges_until(1'b1, 500, lat);
      check_int("R5", "restarted latency edges", lat, REL + 3);

      // R7 / R9: long warm reset
      tag = "R7";
      step(5);
      host_rst_n = 1'b0;
      edges_until(1'b0, 20, lat);
      check_int("R7", "warm assert latency edges", lat, 3);
      for (int i = 0; i < 50; i++) begin
         step(1);
         if (i % 10 == 0) check("R7", "pull untouched by warm", clken_pull_low, 1'b0);
      end
      tag = "R9";
      host_rst_n = 1'b1;
      edges_until(1'b1, 20, lat);
      check_int("R9", "warm release latency edges", lat, 3);

      // R8: one-cycle warm pulse
      tag = "R8";
      step(5);
      host_rst_n = 1'b0;
      step(1);
      host_rst_n = 1'b1;
      edges_until(1'b0, 20, lat);
      lowc = 1;
      while (lowc < 500) begin
         step(1);
         if (card_rst_n === 1'b1) break;
         lowc++;
      end
      check_int("R8", "minimum pulse width cycles", lowc, MINW);

      // Random stretches compared against the model every cycle
      tag = "R2";
      for (int seg = 0; seg < 60; seg++) begin
         int pick;
         pick = int'($urandom_range(0, 5));
         case (pick)
            0: rails = NR'($urandom_range(0, (1 << NR) - 2));
            1: host_rst_n = 1'b0;
            2: ext_hold = 1'b1;
            default: begin
               rails = '1; host_rst_n = 1'b1; ext_hold = 1'b0;
            end
         endcase
         step(int'($urandom_range(1, 90)));
         if (pick < 3 && $urandom_range(0, 1) == 1) begin
            rails = '1; host_rst_n = 1'b1; ext_hold = 1'b0;
            step(int'($urandom_range(1, 120)));
         end
      end

      done = 1;
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end
endmodule